// File: doc/BRIEF.md
# External Interrupt Configuration Controller

This block watches four asynchronous external interrupt lines and turns them into one combined interrupt request. Each line can be set up on its own. A polarity bit chooses active-high or active-low. A mode bit chooses level or edge detection. A third bit makes an edge-mode line respond to transitions in either direction. Every line also has a status bit, a write-one-to-clear bit and an enable mask bit.

All of these settings sit in one 32-bit configuration word. Each field of that word is four bits wide and holds one bit per line. Software writes the word through a single-cycle write strobe and reads it back on a continuously driven read bus.

Each raw input passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with the value it had one cycle earlier. An edge-mode status bit stays latched until software clears it. A level-mode status bit follows the synchronized input directly. The interrupt output is raised whenever any status bit with its mask bit set is 1.

Top module: `xirq_cfg_ctrl`

## Requirements
- R1: After reset, the read bus reads 0 and irq_o is 0.
- R2: The word layout is as follows, with bit n of each field belonging to line n: polarity at bits 3:0, status at 7:4, clear at 11:8, mask at 15:12, either-edge at 19:16, level mode at 23:20. The polarity, mask, either-edge and level fields read back what was last written. Writes to the status field and to bits 31:24 are ignored, and those upper bits read 0. The clear field always reads 0.
- R3: In edge mode (level bit 0) with polarity 1, a rising transition on a line sets its status bit. If a change on line_i is sampled at clock edge k, the status bit reads 1 after edge k+2.
- R4: In edge mode with polarity 0, a falling transition sets the status bit. A transition in the opposite direction from the selected one sets nothing.
- R5: In edge mode with the either-edge bit at 1, both rising and falling transitions set the status bit, whatever the polarity bit holds.
- R6: An edge-mode status bit stays at 1 after the input returns to its idle value, and it stays at 1 until it is cleared.
- R7: Writing 1 to a clear bit resets the edge-mode status bit of that line only. Writing 0 to a clear bit leaves the status unchanged.
- R8: In level mode (level bit 1), the status bit reads the synchronized input when polarity is 1 and its inverse when polarity is 0. A change sampled at edge k shows after edge k+1. The status is not latched, and clear writes do not change it.
- R9: irq_o is 1 exactly when some line has both its status bit and its mask bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Data to write |
| rd_data_o | output | 32 | Current value of the configuration word |
| line_i | input | 4 | Raw asynchronous interrupt lines |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The assertions check several properties on every cycle:
- a detected edge always latches its status bit;
- a latched bit holds until it is cleared;
- a clear pulse with no competing event empties the latch;
- in either-edge mode every synchronized change counts as an event, and in single-edge mode an unchanged input never does;
- the clear field always reads 0 and the settings hold steady without a write;
- an all-zero mask keeps irq_o low.

Some behaviour only the bench scenarios can show. These are the exact latency of the two synchronizer stages, the polarity choice in level mode, and the fact that a clear touches only its own line. The bench sweeps every polarity, either-edge and level combination on each of the four lines to show them.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  // Index of each field inside the configuration word; a field starts at index*lines.
  localparam int F_POL   = 0;
  localparam int F_STAT  = 1;
  localparam int F_CLR   = 2;
  localparam int F_MASK  = 3;
  localparam int F_ANY   = 4;
  localparam int F_LVL   = 5;
  localparam int F_COUNT = 6;

  function automatic int field_lsb(input int fidx, input int lines);
    return fidx * lines;
  endfunction

  // Transition qualifies as an event for the given polarity / either-edge choice.
  function automatic logic edge_hit(input logic prev, input logic cur,
                                    input logic pol, input logic any_edge);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (any_edge) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Level-mode status: active when the synchronized input matches polarity.
  function automatic logic level_active(input logic cur, input logic pol);
    return ~(cur ^ pol);
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/xirq_cfg.sv
module xirq_cfg #(
  parameter int LINES = 4,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [LINES-1:0] pol_o,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] any_o,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] clr_o
);

  localparam int POL_LSB  = xirq_pkg::field_lsb(xirq_pkg::F_POL,  LINES);
  localparam int CLR_LSB  = xirq_pkg::field_lsb(xirq_pkg::F_CLR,  LINES);
  localparam int MASK_LSB = xirq_pkg::field_lsb(xirq_pkg::F_MASK, LINES);
  localparam int ANY_LSB  = xirq_pkg::field_lsb(xirq_pkg::F_ANY,  LINES);
  localparam int LVL_LSB  = xirq_pkg::field_lsb(xirq_pkg::F_LVL,  LINES);

  logic [LINES-1:0] pol_q, mask_q, any_q, lvl_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      mask_q <= '0;
      any_q  <= '0;
      lvl_q  <= '0;
    end else if (wr_en_i) begin
      pol_q  <= wr_data_i[POL_LSB  +: LINES];
      mask_q <= wr_data_i[MASK_LSB +: LINES];
      any_q  <= wr_data_i[ANY_LSB  +: LINES];
      lvl_q  <= wr_data_i[LVL_LSB  +: LINES];
    end
  end

  // Clear is a one-cycle pulse taken straight from the write; it is never stored.
  assign clr_o  = wr_en_i ? wr_data_i[CLR_LSB +: LINES] : '0;
  assign pol_o  = pol_q;
  assign mask_o = mask_q;
  assign any_o  = any_q;
  assign lvl_o  = lvl_q;

  // R2: settings move only on a write
  a_r2_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pol_q) && $stable(mask_q) && $stable(any_q) && $stable(lvl_q)));

endmodule

// File: rtl/xirq_line.sv
module xirq_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic prev_i,
  input  logic pol_i,
  input  logic any_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic evt_o,
  output logic status_o
);

  logic latch_q;

  // Event only counts in edge mode.
  assign evt_o = ~lvl_i & xirq_pkg::edge_hit(prev_i, cur_i, pol_i, any_i);

  // A new event wins over a clear in the same cycle so no edge is lost.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     latch_q <= 1'b0;
    else if (evt_o)  latch_q <= 1'b1;
    else if (clr_i)  latch_q <= 1'b0;
  end

  assign status_o = lvl_i ? xirq_pkg::level_active(cur_i, pol_i) : latch_q;

  // R3: a detected edge is latched on the next clock
  a_r3_evt_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> latch_q);

  // R6: a latched bit holds without a clear
  a_r6_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !clr_i) |=> latch_q);

  // R7: a clear with no competing event empties the latch
  a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_o) |=> !latch_q);

  // R5: either-edge mode reacts to every synchronized change
  a_r5_any_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && any_i && (cur_i != prev_i)) |-> evt_o);

  // R4: an unchanged input never produces an event
  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i == prev_i) |-> !evt_o);

endmodule

// File: rtl/xirq_cfg_ctrl.sv
module xirq_cfg_ctrl #(
  parameter int LINES = 4,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [LINES-1:0] line_i,
  output logic             irq_o
);

  localparam int POL_LSB  = xirq_pkg::field_lsb(xirq_pkg::F_POL,  LINES);
  localparam int STAT_LSB = xirq_pkg::field_lsb(xirq_pkg::F_STAT, LINES);
  localparam int CLR_LSB  = xirq_pkg::field_lsb(xirq_pkg::F_CLR,  LINES);
  localparam int MASK_LSB = xirq_pkg::field_lsb(xirq_pkg::F_MASK, LINES);
  localparam int ANY_LSB  = xirq_pkg::field_lsb(xirq_pkg::F_ANY,  LINES);
  localparam int LVL_LSB  = xirq_pkg::field_lsb(xirq_pkg::F_LVL,  LINES);
  localparam int USED_W   = xirq_pkg::F_COUNT * LINES;

  initial begin
    if (USED_W > DW) $error("configuration word too narrow for %0d lines", LINES);
  end

  logic [LINES-1:0] cur_w, prev_w;
  logic [LINES-1:0] pol_w, mask_w, any_w, lvl_w, clr_w;
  logic [LINES-1:0] evt_w, status_w;

  xirq_sync #(.WIDTH(LINES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (line_i),
    .cur_o  (cur_w),
    .prev_o (prev_w)
  );

  xirq_cfg #(.LINES(LINES), .DW(DW)) cfg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .pol_o     (pol_w),
    .mask_o    (mask_w),
    .any_o     (any_w),
    .lvl_o     (lvl_w),
    .clr_o     (clr_w)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    xirq_line line_u (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cur_i    (cur_w[n]),
      .prev_i   (prev_w[n]),
      .pol_i    (pol_w[n]),
      .any_i    (any_w[n]),
      .lvl_i    (lvl_w[n]),
      .clr_i    (clr_w[n]),
      .evt_o    (evt_w[n]),
      .status_o (status_w[n])
    );
  end

  logic unused_evt;
  assign unused_evt = ^evt_w;

  always_comb begin
    rd_data_o = '0;
    rd_data_o[POL_LSB  +: LINES] = pol_w;
    rd_data_o[STAT_LSB +: LINES] = status_w;
    rd_data_o[MASK_LSB +: LINES] = mask_w;
    rd_data_o[ANY_LSB  +: LINES] = any_w;
    rd_data_o[LVL_LSB  +: LINES] = lvl_w;
  end

  assign irq_o = |(status_w & mask_w);

  // R2: clear field is write-only
  a_r2_clear_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[CLR_LSB +: LINES] == '0);

  // R9: nothing enabled means no request
  a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[MASK_LSB +: LINES] == '0) |-> !irq_o);

endmodule

// File: tb/xirq_cfg_ctrl_tb.sv
module xirq_cfg_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  lines = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xirq_cfg_ctrl dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .line_i    (lines),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] word(input logic [3:0] lvl, input logic [3:0] any,
                                       input logic [3:0] msk, input logic [3:0] clr,
                                       input logic [3:0] pol);
    return {8'h00, lvl, any, msk, clr, 4'h0, pol};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] st;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    chk("R1 read", rd_data, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    wcfg(32'hFFFF_FFFF);
    chk("R2 all ones", rd_data, 32'h00FF_F00F);
    wcfg(32'h0059_A003);
    chk("R2 pattern", rd_data, 32'h0059_A043);
    chk("R9 pattern irq", {31'h0, irq}, 32'h0);
    wcfg(32'h0);
    chk("R2 zero", rd_data, 32'h0);

    for (int c = 0; c < 8; c++) begin
      for (int j = 0; j < 4; j++) begin
        logic pol, any, lvl;
        logic [3:0] m;
        pol = c[0]; any = c[1]; lvl = c[2];
        m = 4'b1 << j;
        wcfg(word({4{lvl}}, {4{any}}, m, 4'hF, {4{pol}}));
        st = lvl ? (pol ? 4'h0 : 4'hF) : 4'h0;
        chk(lvl ? "R8 idle" : "R7 idle", {28'h0, rd_data[7:4]}, {28'h0, st});
        chk("R9 idle", {31'h0, irq}, {31'h0, st[j]});

        lines[j] = 1'b1;
        waitn(3);
        if (lvl) begin
          st = pol ? 4'h0 : 4'hF;
          st[j] = pol;
        end else begin
          st = 4'h0;
          st[j] = any | pol;
        end
        chk(lvl ? "R8 high" : (any ? "R5 rise" : "R3 R4 rise"),
            {28'h0, rd_data[7:4]}, {28'h0, st});
        chk("R9 rise", {31'h0, irq}, {31'h0, st[j]});

        lines[j] = 1'b0;
        waitn(3);
        if (lvl) st = pol ? 4'h0 : 4'hF;
        else st[j] = 1'b1;
        chk(lvl ? "R8 low" : (any ? "R5 fall" : "R4 R6 fall"),
            {28'h0, rd_data[7:4]}, {28'h0, st});

        wcfg(word({4{lvl}}, {4{any}}, m, m, {4{pol}}));
        if (!lvl) st = 4'h0;
        chk(lvl ? "R8 clear ignored" : "R7 clear",
            {28'h0, rd_data[7:4]}, {28'h0, st});
      end
    end

    wcfg(word(4'h0, 4'h0, 4'hF, 4'hF, 4'hF));
    lines = 4'hF;
    waitn(3);
    chk("R3 all rise", {28'h0, rd_data[7:4]}, 32'hF);
    lines = 4'h0;
    waitn(3);
    chk("R6 held", {28'h0, rd_data[7:4]}, 32'hF);
    wcfg(word(4'h0, 4'h0, 4'hF, 4'h0, 4'hF));
    chk("R7 zero clear", {28'h0, rd_data[7:4]}, 32'hF);
    wcfg(word(4'h0, 4'h0, 4'hF, 4'h2, 4'hF));
    chk("R7 one line", {28'h0, rd_data[7:4]}, 32'hD);
    chk("R9 some", {31'h0, irq}, 32'h1);
    wcfg(word(4'h0, 4'h0, 4'h0, 4'h0, 4'hF));
    chk("R9 none masked", {31'h0, irq}, 32'h0);
    wcfg(word(4'h0, 4'h0, 4'h2, 4'h0, 4'hF));
    chk("R9 cleared line", {31'h0, irq}, 32'h0);
    wcfg(word(4'h0, 4'h0, 4'h4, 4'h0, 4'hF));
    chk("R9 set line", {31'h0, irq}, 32'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule